// File: doc/BRIEF.md
# Failsafe Servo Pulse Generator

This block turns signed speed commands from a host into servo-style control pulses on a bank of output channels. Every channel emits one high pulse at the start of each fixed 20 ms frame. The pulse is 1 ms high for full reverse, 1.5 ms for stop and 2 ms for full forward. The host writes an 8-bit two's-complement command into a per-channel register through a simple write strobe with a channel address. The stored command is picked up at the next frame boundary, so a pulse already being driven is never cut short.

Two safety paths override the commands. A command watchdog counts time since the most recent write to any channel. If no write arrives within 50 ms, every channel drops to the neutral 1.5 ms pulse. The block keeps running, and the next write restores all channels to their stored commands. An emergency-stop input forces the same neutral pulse while it is held. A status output reports when either override is active.

All timing is counted in ticks produced by a prescaler. With the default parameters and a 100 MHz clock, one tick is 1 µs.

Top module: `servo_pwm_bank`

## Requirements
- R1: Each channel output rises once every FRAME_TICKS ticks (20 ms by default). All channels rise on the same cycle.
- R2: A stored command c gives a high time of MID + trunc(c' * HALF / 127) ticks, where MID = (MIN_TICKS+MAX_TICKS)/2, HALF = (MAX_TICKS-MIN_TICKS)/2, and c' is c clamped to -127..+127.
- R3: Commands -128 and -127 give exactly MIN_TICKS (1 ms), 0 gives MID (1.5 ms), and +127 gives exactly MAX_TICKS (2 ms). The active width never leaves [MIN_TICKS, MAX_TICKS].
- R4: A write takes effect only from the next frame start. The frame in progress keeps the width it started with.
- R5: A write (wr_en_i high at a clock edge) to any channel restarts the watchdog. failsafe_o rises exactly WDOG_TICKS ticks after the last write when no estop is present.
- R6: Every frame that starts while the failsafe is active has the neutral width MID on all channels, whatever commands are stored.
- R7: After a timeout, a write to any one channel clears the timeout. From the next frame, all channels resume their stored commands.
- R8: After reset, all stored commands are 0, the watchdog is timed out, failsafe_o is 1 and all channels emit the neutral pulse.
- R9: estop_i passes through a two-flop synchronizer, so failsafe_o rises on the second clock edge after estop_i rises. Frames are neutral while it is held, even when the watchdog is being fed. After release, commanded widths resume.
- R10: failsafe_o is high exactly when the watchdog has timed out or the synchronized estop is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command write strobe |
| wr_addr_i | input | $clog2(N_CH) | Channel selected by the write |
| wr_data_i | input | CMD_W | Signed command, two's complement |
| estop_i | input | 1 | Emergency stop, asynchronous, active high |
| pwm_o | output | N_CH | Registered pulse outputs, one bit per channel |
| failsafe_o | output | 1 | High while timed out or stopped |

## Verification
- **Stale or wrong stored command or active width:** it appears as a wrong high time on the affected channel in the first complete frame after the write. It shows within one or two frame periods, so widths are compared per channel for every command value.
- **Frame counter fault:** it shows as a rise spacing other than FRAME_TICKS ticks between consecutive frames.
- **Watchdog counter off by one tick:** it moves the failsafe_o edge, which is sampled on the exact cycles of R5.
- **Override not reaching the width load:** it leaves a commanded width in the first frame that should be neutral.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

  // Saturating linear map from a signed command to a high time in ticks.
  function automatic logic [31:0] cmd_to_ticks(input logic signed [31:0] cmd,
                                               input int cmd_max,
                                               input int mid,
                                               input int half);
    logic signed [31:0] c;
    if (cmd < -cmd_max)      c = -cmd_max;
    else if (cmd > cmd_max)  c = cmd_max;
    else                     c = cmd;
    return 32'(mid + (c * half) / cmd_max);
  endfunction

endpackage

// File: rtl/servo_pwm_timebase.sv
module servo_pwm_timebase #(
  parameter int PRESCALE    = 100,
  parameter int FRAME_TICKS = 20000,
  localparam int POS_W      = $clog2(FRAME_TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_end_o
);

  generate
    if (PRESCALE == 1) begin : g_no_div
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(PRESCALE);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            div_q <= '0;
        else if (div_q == DIV_W'(PRESCALE - 1)) div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DIV_W'(PRESCALE - 1));
    end
  endgenerate

  logic [POS_W-1:0] pos_q;

  assign frame_end_o = tick_o && (pos_q == POS_W'(FRAME_TICKS - 1));
  assign pos_o       = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pos_q <= '0;
    else if (frame_end_o) pos_q <= '0;
    else if (tick_o)      pos_q <= pos_q + 1'b1;
  end

endmodule

// File: rtl/servo_pwm_wdog.sv
module servo_pwm_wdog #(
  parameter int WDOG_TICKS = 50000,
  localparam int CNT_W     = $clog2(WDOG_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kick_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q;

  // starts expired: no command seen yet
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= CNT_W'(WDOG_TICKS);
    else if (kick_i)             cnt_q <= '0;
    else if (tick_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CNT_W'(WDOG_TICKS));

endmodule

// File: rtl/servo_pwm_chan.sv
module servo_pwm_chan
  import servo_pwm_pkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int POS_W     = 15,
  parameter int MIN_TICKS = 1000,
  parameter int MAX_TICKS = 2000,
  localparam int MID      = (MIN_TICKS + MAX_TICKS) / 2,
  localparam int HALF     = (MAX_TICKS - MIN_TICKS) / 2,
  localparam int CMD_MAX  = 2 ** (CMD_W - 1) - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic signed [CMD_W-1:0] data_i,
  input  logic                    frame_end_i,
  input  logic                    failsafe_i,
  input  logic [POS_W-1:0]        pos_i,
  output logic [POS_W-1:0]        width_o,
  output logic                    pwm_o
);

  logic signed [CMD_W-1:0] cmd_q;
  logic [POS_W-1:0]        width_q;
  logic [31:0]             target;
  logic                    pwm_q;

  always_comb begin
    if (failsafe_i) target = 32'(MID);
    else            target = cmd_to_ticks(32'(cmd_q), CMD_MAX, MID, HALF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmd_q <= '0;
    else if (wr_i) cmd_q <= data_i;
  end

  // width only changes at frame boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          width_q <= POS_W'(MID);
    else if (frame_end_i) width_q <= target[POS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= (pos_i < width_q);
  end

  assign width_o = width_q;
  assign pwm_o   = pwm_q;

endmodule

// File: rtl/servo_pwm_bank.sv
module servo_pwm_bank #(
  parameter int N_CH        = 8,
  parameter int CMD_W       = 8,
  parameter int PRESCALE    = 100,
  parameter int FRAME_TICKS = 20000,
  parameter int MIN_TICKS   = 1000,
  parameter int MAX_TICKS   = 2000,
  parameter int WDOG_TICKS  = 50000,
  localparam int ADDR_W     = $clog2(N_CH),
  localparam int POS_W      = $clog2(FRAME_TICKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CMD_W-1:0]  wr_data_i,
  input  logic              estop_i,
  output logic [N_CH-1:0]   pwm_o,
  output logic              failsafe_o
);

  logic                    tick;
  logic [POS_W-1:0]        pos;
  logic                    frame_end;
  logic                    wdog_expired;
  logic                    estop_meta_q;
  logic                    estop_sync;
  logic [N_CH*POS_W-1:0]   width_flat;

  servo_pwm_timebase #(
    .PRESCALE   (PRESCALE),
    .FRAME_TICKS(FRAME_TICKS)
  ) i_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick),
    .pos_o      (pos),
    .frame_end_o(frame_end)
  );

  servo_pwm_wdog #(
    .WDOG_TICKS(WDOG_TICKS)
  ) i_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .kick_i   (wr_en_i),
    .expired_o(wdog_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      estop_meta_q <= 1'b0;
      estop_sync   <= 1'b0;
    end else begin
      estop_meta_q <= estop_i;
      estop_sync   <= estop_meta_q;
    end
  end

  assign failsafe_o = wdog_expired | estop_sync;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    servo_pwm_chan #(
      .CMD_W    (CMD_W),
      .POS_W    (POS_W),
      .MIN_TICKS(MIN_TICKS),
      .MAX_TICKS(MAX_TICKS)
    ) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr_en_i && (wr_addr_i == ADDR_W'(i))),
      .data_i     (wr_data_i),
      .frame_end_i(frame_end),
      .failsafe_i (failsafe_o),
      .pos_i      (pos),
      .width_o    (width_flat[i*POS_W +: POS_W]),
      .pwm_o      (pwm_o[i])
    );
  end

endmodule

// File: rtl/servo_pwm_bank_chk.sv
module servo_pwm_bank_chk #(
  parameter int N_CH      = 8,
  parameter int POS_W     = 15,
  parameter int MIN_TICKS = 1000,
  parameter int MAX_TICKS = 2000,
  localparam int MID      = (MIN_TICKS + MAX_TICKS) / 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  failsafe_o,
  input logic                  wdog_exp_i,
  input logic                  estop_s_i,
  input logic                  frame_end_i,
  input logic [POS_W-1:0]      pos_i,
  input logic [N_CH*POS_W-1:0] width_i,
  input logic [N_CH-1:0]       pwm_o
);

  // R5
  kick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wdog_exp_i);

  // R9
  estop_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    estop_s_i |-> failsafe_o);

  // R10
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_o |-> (wdog_exp_i || estop_s_i));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R3
    width_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (width_i[i*POS_W +: POS_W] >= POS_W'(MIN_TICKS)) &&
      (width_i[i*POS_W +: POS_W] <= POS_W'(MAX_TICKS)));

    // R4
    width_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_end_i |=> $stable(width_i[i*POS_W +: POS_W]));

    // R6
    neutral_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_end_i && failsafe_o) |=> (width_i[i*POS_W +: POS_W] == POS_W'(MID)));

    // R3
    pulse_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_o[i] |-> ($past(pos_i) < POS_W'(MAX_TICKS)));
  end

endmodule

bind servo_pwm_bank servo_pwm_bank_chk #(
  .N_CH     (N_CH),
  .POS_W    (POS_W),
  .MIN_TICKS(MIN_TICKS),
  .MAX_TICKS(MAX_TICKS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .failsafe_o (failsafe_o),
  .wdog_exp_i (wdog_expired),
  .estop_s_i  (estop_sync),
  .frame_end_i(frame_end),
  .pos_i      (pos),
  .width_i    (width_flat),
  .pwm_o      (pwm_o)
);

// File: tb/test_servo_pwm_bank.sv
module test_servo_pwm_bank;

  localparam int NCH   = 8;
  localparam int PRE   = 2;
  localparam int FRAME = 300;
  localparam int MINT  = 100;
  localparam int MAXT  = 200;
  localparam int WDOG  = 700;
  localparam int MIDT  = 150;
  localparam int HALFT = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic       estop = 1'b0;
  logic [NCH-1:0] pwm;
  logic       fs;

  always #5 clk = ~clk;

  servo_pwm_bank #(
    .N_CH(NCH), .CMD_W(8), .PRESCALE(PRE), .FRAME_TICKS(FRAME),
    .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .WDOG_TICKS(WDOG)
  ) i_servo_pwm_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(addr),
    .wr_data_i(data), .estop_i(estop), .pwm_o(pwm), .failsafe_o(fs)
  );

  int total = 0;
  int bad = 0;
  int meas[NCH];
  int acc[NCH];
  int cmd_m[NCH];
  int prev_v[NCH];
  int per_cnt, per_meas, frames;
  logic prev0;

  // frame monitor: high-sample count per channel between rises of channel 0
  always @(negedge clk) begin
    if (!rst_n) begin
      frames = 0; per_cnt = 0; per_meas = 0; prev0 = 1'b0;
      for (int i = 0; i < NCH; i++) begin acc[i] = 0; meas[i] = 0; end
    end else begin
      per_cnt++;
      if (pwm[0] && !prev0) begin
        frames++;
        per_meas = per_cnt;
        per_cnt = 0;
        for (int i = 0; i < NCH; i++) begin meas[i] = acc[i]; acc[i] = int'(pwm[i]); end
      end else begin
        for (int i = 0; i < NCH; i++) acc[i] += int'(pwm[i]);
      end
      prev0 = pwm[0];
    end
  end

  function automatic int exp_w(input int c);
    int cc;
    cc = (c < -127) ? -127 : c;
    return (MIDT + (cc * HALFT) / 127) * PRE;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames + n;
    while (frames < target) @(posedge clk);
  endtask

  task automatic wr(input int ch, input int val);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(ch); data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    cmd_m[ch] = val;
  endtask

  task automatic chk_cmds(input string req);
    for (int i = 0; i < NCH; i++) chk(meas[i] == exp_w(cmd_m[i]), req, meas[i], exp_w(cmd_m[i]));
  endtask

  task automatic chk_neutral(input string req);
    for (int i = 0; i < NCH; i++) chk(meas[i] == MIDT * PRE, req, meas[i], MIDT * PRE);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung act=%0d exp=%0d", frames, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit prev_neu;
    int c;
    for (int i = 0; i < NCH; i++) cmd_m[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    @(negedge clk);
    chk(fs == 1'b1, "R8 failsafe after reset", int'(fs), 1);
    wait_frames(2);
    chk_neutral("R8 neutral after reset");
    chk(per_meas == FRAME * PRE, "R1 frame period", per_meas, FRAME * PRE);

    // sweep all 256 command values, 8 per batch
    prev_neu = 1'b1;
    for (int b = 0; b < 32; b++) begin
      for (int i = 0; i < NCH; i++) prev_v[i] = cmd_m[i];
      for (int i = 0; i < NCH; i++) wr(i, -128 + b * NCH + i);
      wait_frames(1);
      // R4: frame in progress keeps old width
      for (int i = 0; i < NCH; i++) begin
        c = prev_neu ? MIDT * PRE : exp_w(prev_v[i]);
        chk(meas[i] == c, "R4 old width held", meas[i], c);
      end
      wait_frames(1);
      chk_cmds("R2 mapped width");
      chk(per_meas == FRAME * PRE, "R1 frame period", per_meas, FRAME * PRE);
      for (int i = 0; i < NCH; i++) begin
        if (cmd_m[i] == -128 || cmd_m[i] == -127)
          chk(meas[i] == MINT * PRE, "R3 min end", meas[i], MINT * PRE);
        if (cmd_m[i] == 0)
          chk(meas[i] == MIDT * PRE, "R3 center", meas[i], MIDT * PRE);
        if (cmd_m[i] == 127)
          chk(meas[i] == MAXT * PRE, "R3 max end", meas[i], MAXT * PRE);
      end
      prev_neu = 1'b0;
    end

    // R5: watchdog expiry timing
    wr(0, 60);
    repeat ((WDOG - 1) * PRE) @(negedge clk);
    chk(fs == 1'b0, "R5 not yet expired", int'(fs), 0);
    repeat (PRE) @(negedge clk);
    chk(fs == 1'b1, "R5 expired", int'(fs), 1);
    wait_frames(2);
    chk_neutral("R6 neutral on timeout");
    chk(fs == 1'b1, "R10 status on timeout", int'(fs), 1);

    // R7: one write resumes all channels
    wr(3, -40);
    wait_frames(2);
    chk_cmds("R7 resume after timeout");
    chk(fs == 1'b0, "R7 status cleared", int'(fs), 0);

    // R9: emergency stop
    wr(1, -100);
    @(negedge clk);
    estop = 1'b1;
    @(negedge clk);
    chk(fs == 1'b0, "R9 sync delay", int'(fs), 0);
    @(negedge clk);
    chk(fs == 1'b1, "R9 estop flagged", int'(fs), 1);
    wait_frames(2);
    chk_neutral("R9 neutral under estop");
    chk(fs == 1'b1, "R10 status under estop", int'(fs), 1);
    estop = 1'b0;
    wr(2, 5);
    wait_frames(2);
    chk_cmds("R9 resume after estop");
    chk(fs == 1'b0, "R10 status clear", int'(fs), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule